// File: doc/BRIEF.md
# Debug Read-Protection Level Latch and Access Gate

This block sets the debug read-protection level of a microcontroller-style chip and applies it to every debug read. While the chip is in power-on reset the level sits at its strictest value. The first sample strobe after power-on captures an 8-bit protection option byte, decodes it to one of three levels and holds that level. Two byte values are keys: one opens the part and one locks it. Any other value lands on the middle level.

From then on each debug read request is answered one cycle later with a grant or deny bit. A request names its target region, SRAM or flash. Granted reads pass the memory's data word through. Denied reads return zero. A soft reset only clears the response path. The held level survives it, so a wrongly captured byte stays in force until the next power cycle. Writes to the option byte after capture have no effect until then.

Top module: `rdp_guard`

## Requirements
- R1: While `por_n` is low at a clock edge, the level becomes 2, `dbg_enable` becomes 0 and `rsp_valid` becomes 0. Until a strobe is accepted, the level stays 2 and every read is denied.
- R2: An accepted strobe with `opt_byte` = 0xAA sets the level to 0 from the following cycle.
- R3: An accepted strobe with `opt_byte` = 0xCC sets the level to 2 from the following cycle.
- R4: An accepted strobe with any other `opt_byte` value sets the level to 1 from the following cycle.
- R5: A strobe is accepted only if `por_n` and `soft_rst_n` are high and no strobe has been accepted since the last power-on reset. Later strobes, and any change of `opt_byte`, leave the level unchanged.
- R6: A soft reset (`soft_rst_n` low) never changes the level. A strobe given during a soft reset is ignored.
- R7: `rd_region` is 0 for SRAM and 1 for flash. Level 0 grants both regions, level 1 grants SRAM and denies flash, and level 2 denies both.
- R8: `rsp_valid` is 1 in exactly the cycle after a cycle with `rd_req` high and `soft_rst_n` high; otherwise it is 0. A request made during a soft reset gets no response.
- R9: A granted response carries the `rd_data_in` value presented with its request on `rsp_data`. A denied response carries all zeros.
- R10: `dbg_enable` is 1 exactly when the held level is below 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| soft_rst_n | input | 1 | Soft reset, active low, synchronous; keeps the level |
| opt_byte | input | 8 | Protection option byte value |
| opt_sample | input | 1 | Sample strobe for the option byte |
| rd_req | input | 1 | Debug read request |
| rd_region | input | 1 | Target region: 0 SRAM, 1 flash |
| rd_data_in | input | DATA_W | Memory data presented with the request |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_grant | output | 1 | 1 granted, 0 denied |
| rsp_data | output | DATA_W | Read data, zero when denied |
| level | output | 2 | Held protection level (0, 1 or 2) |
| dbg_enable | output | 1 | Debug probe access enabled |

## Verification
The hardest situation to reach from the ports is a middle level captured from a non-key byte that must persist across soft resets, later strobes and a rewritten option byte (including the locking key). To reach it, each random power cycle captures a byte weighted toward the two keys and their near misses. The rest of the cycle mixes soft-reset pulses, extra strobes with fresh byte values and SRAM and flash reads. Directed cases cover a strobe given inside a soft reset before any capture, and reads before the first capture.

// File: rtl/rdp_pkg.sv
// Package: shared level encoding and option-byte keys for the read-protection block.
// Assumes an 8-bit option byte; level codes are ordered from open (0) to locked (2).
package rdp_pkg;
    localparam int OPT_W = 8;
    localparam int LVL_W = 2;

    typedef enum logic [LVL_W-1:0] {
        LVL_OPEN   = 2'd0,
        LVL_RAM    = 2'd1,
        LVL_LOCKED = 2'd2
    } prot_lvl_e;

    localparam logic [OPT_W-1:0] KEY_OPEN   = 8'hAA;
    localparam logic [OPT_W-1:0] KEY_LOCKED = 8'hCC;
endpackage

// File: rtl/rdp_level_decode.sv
// Module: maps a raw option byte to a protection level.
// Assumes the two key values differ; every non-key value maps to the middle level.
module rdp_level_decode
    import rdp_pkg::*;
#(
    parameter logic [OPT_W-1:0] OPEN_KEY   = KEY_OPEN,
    parameter logic [OPT_W-1:0] LOCKED_KEY = KEY_LOCKED
) (
    input  logic [OPT_W-1:0] opt_byte,
    output prot_lvl_e        dec_lvl
);
    // Key compare: exact match for open/locked, everything else is SRAM-only.
    always_comb begin
        if (opt_byte == OPEN_KEY)
            dec_lvl = LVL_OPEN;
        else if (opt_byte == LOCKED_KEY)
            dec_lvl = LVL_LOCKED;
        else
            dec_lvl = LVL_RAM;
    end
endmodule

// File: rtl/rdp_level_latch.sv
// Module: holds the protection level, captured once per power-on.
// Assumes por_n and soft_rst_n are synchronous, active low; soft reset never
// touches the held level, and a strobe inside a soft reset is ignored.
module rdp_level_latch
    import rdp_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic             soft_rst_n,
    input  logic             opt_sample,
    input  logic [OPT_W-1:0] opt_byte,
    input  prot_lvl_e        dec_lvl,
    output prot_lvl_e        lvl_q,
    output logic             taken_q
);
    logic accept;

    // Strobe acceptance: first strobe outside soft reset since power-on.
    always_comb accept = opt_sample && !taken_q && soft_rst_n;

    // Level register: locked on power-on, loaded once by an accepted strobe.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            lvl_q   <= LVL_LOCKED;
            taken_q <= 1'b0;
        end else if (accept) begin
            lvl_q   <= dec_lvl;
            taken_q <= 1'b1;
        end
    end

    assert_open_key_R2: assert property (@(posedge clk) disable iff (!por_n)
        (opt_sample && !taken_q && soft_rst_n && opt_byte == KEY_OPEN) |=> (lvl_q == LVL_OPEN));

    assert_locked_key_R3: assert property (@(posedge clk) disable iff (!por_n)
        (opt_sample && !taken_q && soft_rst_n && opt_byte == KEY_LOCKED) |=> (lvl_q == LVL_LOCKED));

    assert_once_per_power_R5: assert property (@(posedge clk) disable iff (!por_n)
        taken_q |=> $stable(lvl_q));

    assert_soft_keeps_level_R6: assert property (@(posedge clk) disable iff (!por_n)
        !soft_rst_n |=> $stable(lvl_q));

    assert_unlock_needs_sample_R10: assert property (@(posedge clk) disable iff (!por_n)
        (lvl_q != LVL_LOCKED) |-> taken_q);
endmodule

// File: rtl/rdp_access_gate.sv
// Module: answers each debug read one cycle later with grant/deny and data.
// Assumes the memory presents its data word in the same cycle as the request.
module rdp_access_gate
    import rdp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              soft_rst_n,
    input  prot_lvl_e         lvl,
    input  logic              rd_req,
    input  logic              rd_region,
    input  logic [DATA_W-1:0] rd_data_in,
    output logic              rsp_valid,
    output logic              rsp_grant,
    output logic [DATA_W-1:0] rsp_data
);
    localparam logic REGION_FLASH = 1'b1;
    logic allow;

    // Permission table: open grants all, SRAM-only denies flash, locked denies all.
    always_comb begin
        unique case (lvl)
            LVL_OPEN: allow = 1'b1;
            LVL_RAM:  allow = (rd_region != REGION_FLASH);
            default:  allow = 1'b0;
        endcase
    end

    // Response register: one-cycle reply, zero data on deny, cleared by either reset.
    always_ff @(posedge clk) begin
        if (!por_n || !soft_rst_n) begin
            rsp_valid <= 1'b0;
            rsp_grant <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= rd_req;
            rsp_grant <= rd_req && allow;
            rsp_data  <= (rd_req && allow) ? rd_data_in : '0;
        end
    end

    assert_reply_next_cycle_R8: assert property (@(posedge clk) disable iff (!por_n)
        (rd_req && soft_rst_n) |=> rsp_valid);

    assert_no_spurious_reply_R8: assert property (@(posedge clk) disable iff (!por_n)
        !(rd_req && soft_rst_n) |=> !rsp_valid);

    assert_locked_denies_R7: assert property (@(posedge clk) disable iff (!por_n)
        (rd_req && soft_rst_n && lvl == LVL_LOCKED) |=> (!rsp_grant && rsp_data == '0));

    assert_flash_denied_mid_R7: assert property (@(posedge clk) disable iff (!por_n)
        (rd_req && soft_rst_n && lvl == LVL_RAM && rd_region) |=> !rsp_grant);

    assert_grant_passes_data_R9: assert property (@(posedge clk) disable iff (!por_n)
        (rd_req && soft_rst_n && lvl == LVL_OPEN) |=> (rsp_grant && rsp_data == $past(rd_data_in)));
endmodule

// File: rtl/rdp_guard.sv
// Module: top of the read-protection block; decodes, holds and applies the level.
// Assumes a single clock; both resets are synchronous and active low.
module rdp_guard
    import rdp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              soft_rst_n,
    input  logic [7:0]        opt_byte,
    input  logic              opt_sample,
    input  logic              rd_req,
    input  logic              rd_region,
    input  logic [DATA_W-1:0] rd_data_in,
    output logic              rsp_valid,
    output logic              rsp_grant,
    output logic [DATA_W-1:0] rsp_data,
    output logic [1:0]        level,
    output logic              dbg_enable
);
    prot_lvl_e dec_lvl;
    prot_lvl_e lvl_q;
    logic      taken_q;

    rdp_level_decode u_decode (
        .opt_byte (opt_byte),
        .dec_lvl  (dec_lvl)
    );

    rdp_level_latch u_latch (
        .clk        (clk),
        .por_n      (por_n),
        .soft_rst_n (soft_rst_n),
        .opt_sample (opt_sample),
        .opt_byte   (opt_byte),
        .dec_lvl    (dec_lvl),
        .lvl_q      (lvl_q),
        .taken_q    (taken_q)
    );

    rdp_access_gate #(.DATA_W(DATA_W)) u_gate (
        .clk        (clk),
        .por_n      (por_n),
        .soft_rst_n (soft_rst_n),
        .lvl        (lvl_q),
        .rd_req     (rd_req),
        .rd_region  (rd_region),
        .rd_data_in (rd_data_in),
        .rsp_valid  (rsp_valid),
        .rsp_grant  (rsp_grant),
        .rsp_data   (rsp_data)
    );

    // Status outputs: raw level code and probe enable below the locked level.
    always_comb begin
        level      = lvl_q;
        dbg_enable = (lvl_q != LVL_LOCKED);
    end

    assert_mid_level_flash_R4: assert property (@(posedge clk) disable iff (!por_n)
        (opt_sample && !taken_q && soft_rst_n && opt_byte != KEY_OPEN && opt_byte != KEY_LOCKED)
        |=> (level == 2'd1 && dbg_enable));
endmodule

// File: tb/rdp_guard_tb.sv
// Bench: directed corners plus seeded random power cycles against a bench model.
module rdp_guard_tb;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              por_n = 1'b0;
    logic              soft_rst_n = 1'b1;
    logic [7:0]        opt_byte = 8'h00;
    logic              opt_sample = 1'b0;
    logic              rd_req = 1'b0;
    logic              rd_region = 1'b0;
    logic [DATA_W-1:0] rd_data_in = '0;
    logic              rsp_valid, rsp_grant, dbg_enable;
    logic [DATA_W-1:0] rsp_data;
    logic [1:0]        level;

    int tests = 0;
    int fails = 0;
    int exp_lvl = 2;
    bit taken = 1'b0;

    always #5 clk = ~clk;

    rdp_guard #(.DATA_W(DATA_W)) u_dut (
        .clk(clk), .por_n(por_n), .soft_rst_n(soft_rst_n), .opt_byte(opt_byte),
        .opt_sample(opt_sample), .rd_req(rd_req), .rd_region(rd_region),
        .rd_data_in(rd_data_in), .rsp_valid(rsp_valid), .rsp_grant(rsp_grant),
        .rsp_data(rsp_data), .level(level), .dbg_enable(dbg_enable)
    );

    function automatic int lvl_of(input logic [7:0] b);
        if (b == 8'hAA) return 0;
        if (b == 8'hCC) return 2;
        return 1;
    endfunction

    function automatic bit grant_of(input int l, input logic region);
        if (l == 0) return 1'b1;
        if (l == 1) return !region;
        return 1'b0;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_level(input string req);
        check(level == exp_lvl[1:0], req, "level", {30'd0, level}, exp_lvl);
        check(dbg_enable == (exp_lvl < 2), "R10", "dbg_enable", {31'd0, dbg_enable},
              {31'd0, (exp_lvl < 2)});
    endtask

    task automatic power_on();
        @(negedge clk);
        por_n = 1'b0; soft_rst_n = 1'b1; opt_sample = 1'b0; rd_req = 1'b0;
        repeat (2) @(negedge clk);
        exp_lvl = 2; taken = 1'b0;
        check(rsp_valid == 1'b0, "R1", "rsp_valid after por", {31'd0, rsp_valid}, 0);
        check_level("R1");
        por_n = 1'b1;
    endtask

    task automatic strobe(input logic [7:0] b, input bit in_soft);
        @(negedge clk);
        opt_byte = b; opt_sample = 1'b1; soft_rst_n = !in_soft;
        @(negedge clk);
        opt_sample = 1'b0; soft_rst_n = 1'b1;
        if (!taken && !in_soft) begin
            exp_lvl = lvl_of(b); taken = 1'b1;
        end
        if (in_soft) check_level("R6");
        else if (exp_lvl == 0) check_level("R2");
        else if (exp_lvl == 2 && taken) check_level("R3");
        else check_level(taken ? "R4" : "R5");
    endtask

    task automatic read(input logic region, input logic [DATA_W-1:0] d);
        bit g;
        @(negedge clk);
        rd_req = 1'b1; rd_region = region; rd_data_in = d;
        @(posedge clk); #1;
        g = grant_of(exp_lvl, region);
        check(rsp_valid == 1'b1, "R8", "rsp_valid", {31'd0, rsp_valid}, 1);
        check(rsp_grant == g, "R7", "rsp_grant", {31'd0, rsp_grant}, {31'd0, g});
        check(rsp_data == (g ? d : '0), "R9", "rsp_data", rsp_data, g ? d : '0);
        @(negedge clk);
        rd_req = 1'b0; rd_data_in = $urandom;
        @(posedge clk); #1;
        check(rsp_valid == 1'b0, "R8", "idle rsp_valid", {31'd0, rsp_valid}, 0);
    endtask

    task automatic soft_pulse();
        @(negedge clk);
        soft_rst_n = 1'b0; rd_req = 1'b1; rd_region = $urandom_range(0, 1);
        @(negedge clk);
        soft_rst_n = 1'b1; rd_req = 1'b0;
        check(rsp_valid == 1'b0, "R8", "reply to request in soft reset", {31'd0, rsp_valid}, 0);
        check_level("R6");
    endtask

    function automatic logic [7:0] pick_byte();
        case ($urandom_range(0, 5))
            0: return 8'hAA;
            1: return 8'hCC;
            2: return 8'hAB;
            3: return 8'hCD;
            default: return 8'($urandom);
        endcase
    endfunction

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        // Directed: locked before any capture, strobe in soft reset ignored.
        power_on();
        read(1'b0, 32'hDEAD_BEEF);
        read(1'b1, 32'h1234_5678);
        strobe(8'hAA, 1'b1);
        read(1'b0, 32'h0BAD_F00D);
        strobe(8'h5A, 1'b0);
        read(1'b0, 32'hCAFE_0001);
        read(1'b1, 32'hCAFE_0002);
        // Directed: mid level survives rewrite to the locking key and soft reset.
        opt_byte = 8'hCC;
        strobe(8'hCC, 1'b0);
        soft_pulse();
        read(1'b0, 32'h0000_0011);
        // Directed: each key on a fresh power cycle.
        power_on();
        strobe(8'hAA, 1'b0);
        read(1'b1, 32'hFFFF_FFFF);
        strobe(8'hCC, 1'b0);
        power_on();
        strobe(8'hCC, 1'b0);
        read(1'b0, 32'h7777_7777);
        strobe(8'hAA, 1'b0);
        // Random power cycles.
        for (int cyc = 0; cyc < 60; cyc++) begin
            power_on();
            if ($urandom_range(0, 3) == 0) strobe(pick_byte(), 1'b1);
            strobe(pick_byte(), 1'b0);
            for (int op = 0; op < 12; op++) begin
                case ($urandom_range(0, 5))
                    0: strobe(pick_byte(), $urandom_range(0, 1) == 1);
                    1: soft_pulse();
                    default: read($urandom_range(0, 1) == 1, $urandom);
                endcase
            end
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule